// File: doc/BRIEF.md
# Status Channel Framing Controller

This block drives the receive-side status channel of a packet interface sink. It sends a 2-bit status word on every clock, grouped into frames. Each frame opens with a framing word and then carries one status entry per calendar slot. The calendar visits the ports in ascending order and is repeated a set number of times. A parity word over the frame's entries closes the frame. The peer reads these frames to learn how much space each port's buffer has.

A second part watches the per-cycle DIP-4 results from the data path. It tracks runs of consecutive errors and consecutive clean results. It raises an out-of-service flag once the error run reaches a programmable threshold. It clears the flag after a programmable number of clean results. These results are ignored until the alignment-lock input is high.

Software or user logic can ask the peer to retrain by raising a force input. The block then finishes the frame in progress and sends the framing pattern continuously. When the input drops, it starts a fresh frame. The force input has no effect on error tracking.

Top module: `status_framer`

## Requirements
- R1: After reset, `stat_out` is 2'b11 (a framing word, start of frame), and `oos`, `force_active` and `dip4_err_seen` are 0.
- R2: A normal frame is one framing word 2'b11, then CAL_LEN×CAL_M entries, then one parity word. Entry k of the frame carries the current value of `port_status[2*(k mod CAL_LEN)+1 : 2*(k mod CAL_LEN)]`, so ports are visited in ascending order and the calendar is repeated CAL_M times.
- R3: The parity word is the bitwise inverse of the XOR of all 2-bit entries sent in that frame.
- R4: While `force_active` is 1, `stat_out` is 2'b11.
- R5: When `force_train` is 1, `force_active` rises only in the cycle after the parity word of the frame in progress is sent.
- R6: When `force_train` is 0 while `force_active` is 1, the next cycle has `force_active` 0 and begins a new frame with its framing word.
- R7: A DIP-4 result counts as an error when any bit of `dip4_err` is 1 while `dip4_vld` is 1. When the run of consecutive errors reaches `bad_level`, `oos` becomes 1 in the next cycle.
- R8: A result with `dip4_vld` 1 and all `dip4_err` bits 0 resets the error run to zero.
- R9: While `oos` is 1, it clears in the cycle after the run of consecutive clean results reaches `good_level`. An error result restarts that run.
- R10: While `lock` is 0, DIP-4 results are ignored. The runs and `oos` hold their values, and `dip4_err_seen` stays 0.
- R11: `dip4_err_seen` is 1 for exactly one cycle after each cycle with an error result, however many lanes flag an error in that cycle.
- R12: `force_train` and `force_active` have no effect on `oos` or `dip4_err_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock | input | 1 | Alignment lock; DIP-4 results are used only when high |
| port_status | input | 2*CAL_LEN | 2-bit status of each port, port p in bits [2p+1:2p] |
| force_train | input | 1 | Request continuous framing |
| dip4_vld | input | 1 | A DIP-4 result is present this cycle |
| dip4_err | input | LANES | Per-lane DIP-4 error flags |
| bad_level | input | CW | Error-run threshold for raising `oos` |
| good_level | input | CW | Clean-run threshold for clearing `oos` |
| stat_out | output | 2 | Status channel word |
| force_active | output | 1 | Continuous framing is being sent |
| oos | output | 1 | Out-of-service indication |
| dip4_err_seen | output | 1 | One-cycle pulse after an error result |

## Verification
Some rules are checked by assertions on every cycle:
- the 2'b11 pattern during forced framing;
- entry into forced framing only right after a parity word;
- the framing word on exit;
- `oos` and the error pulse holding still while unlocked;
- `oos` rising only after an error result.

Other behaviour depends on the history of a whole frame or of a run of results, and only the bench's scenarios can show it. This covers:
- the slot-to-port order;
- the parity value;
- the threshold counts;
- a clean result breaking an error run;
- force having no effect on error tracking.

The bench's reference model compares every output on every clock.

// File: rtl/status_framer.sv
module status_framer #(
  parameter int CAL_LEN = 4,
  parameter int CAL_M   = 2,
  parameter int LANES   = 4,
  parameter int CW      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock,
  input  logic [2*CAL_LEN-1:0] port_status,
  input  logic                 force_train,
  input  logic                 dip4_vld,
  input  logic [LANES-1:0]     dip4_err,
  input  logic [CW-1:0]        bad_level,
  input  logic [CW-1:0]        good_level,
  output logic [1:0]           stat_out,
  output logic                 force_active,
  output logic                 oos,
  output logic                 dip4_err_seen
);
  localparam int N  = CAL_LEN * CAL_M;
  localparam int PW = $clog2(N + 2);
  localparam int SW = (CAL_LEN > 1) ? $clog2(CAL_LEN) : 1;
  localparam logic [PW-1:0] LAST_P = PW'(N + 1);
  localparam logic [SW-1:0] SLOT_END = SW'(CAL_LEN - 1);
  localparam logic [CW-1:0] CMAX = '1;

  logic [PW-1:0] pos;
  logic [SW-1:0] slot;
  logic [1:0]    par;
  logic [1:0]    entry;
  logic [CW-1:0] bad_cnt, good_cnt, bad_nx, good_nx;
  logic          hit, clean;

  assign entry = port_status[slot*2 +: 2];
  assign stat_out = force_active      ? 2'b11 :
                    (pos == '0)       ? 2'b11 :
                    (pos == LAST_P)   ? ~par  : entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_active <= 1'b0;
      pos  <= '0;
      slot <= '0;
      par  <= '0;
    end else if (force_active) begin
      if (!force_train) begin
        force_active <= 1'b0;
        pos  <= '0;
        slot <= '0;
        par  <= '0;
      end
    end else if (pos == LAST_P) begin
      force_active <= force_train;
      pos  <= '0;
      slot <= '0;
      par  <= '0;
    end else begin
      pos <= pos + 1'b1;
      if (pos != '0) begin
        par  <= par ^ entry;
        slot <= (slot == SLOT_END) ? '0 : slot + 1'b1;
      end
    end
  end

  assign hit     = lock && dip4_vld && (|dip4_err);
  assign clean   = lock && dip4_vld && !(|dip4_err);
  assign bad_nx  = (bad_cnt == CMAX) ? bad_cnt : bad_cnt + 1'b1;
  assign good_nx = (good_cnt == CMAX) ? good_cnt : good_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_cnt  <= '0;
      good_cnt <= '0;
      oos      <= 1'b0;
      dip4_err_seen <= 1'b0;
    end else begin
      dip4_err_seen <= hit;
      if (hit) begin
        bad_cnt  <= bad_nx;
        good_cnt <= '0;
        if (bad_nx >= bad_level) oos <= 1'b1;
      end else if (clean) begin
        bad_cnt <= '0;
        if (oos) begin
          if (good_nx >= good_level) begin
            oos      <= 1'b0;
            good_cnt <= '0;
          end else begin
            good_cnt <= good_nx;
          end
        end else begin
          good_cnt <= '0;
        end
      end
    end
  end

  a_r4_cont_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    force_active |-> stat_out == 2'b11);
  a_r5_enter_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_active) |-> $past(pos) == LAST_P);
  a_r6_resume_framing: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_active) |-> (pos == '0 && stat_out == 2'b11));
  a_r10_unlocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> ($stable(oos) && !dip4_err_seen));
  a_r7_oos_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oos) |-> $past(lock && dip4_vld && (|dip4_err)));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dip4_err_seen |-> $past(lock && dip4_vld && (|dip4_err)));
endmodule

// File: tb/status_framer_tb.sv
module status_framer_tb;
  localparam int CAL_LEN = 4, CAL_M = 2, LANES = 4, CW = 4;
  localparam int N = CAL_LEN * CAL_M;

  logic clk = 0, rst_n = 0, lock = 0, force_train = 0, dip4_vld = 0;
  logic [2*CAL_LEN-1:0] port_status = '0;
  logic [LANES-1:0] dip4_err = '0;
  logic [CW-1:0] bad_level = 4'd3, good_level = 4'd2;
  logic [1:0] stat_out;
  logic force_active, oos, dip4_err_seen;

  int total = 0, bad = 0, cyc = 0;
  int m_cont = 0, m_pos = 0, m_slot = 0, m_par = 0;
  int m_bad = 0, m_good = 0, m_oos = 0, m_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  status_framer #(.CAL_LEN(CAL_LEN), .CAL_M(CAL_M), .LANES(LANES), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock(lock), .port_status(port_status),
    .force_train(force_train), .dip4_vld(dip4_vld), .dip4_err(dip4_err),
    .bad_level(bad_level), .good_level(good_level), .stat_out(stat_out),
    .force_active(force_active), .oos(oos), .dip4_err_seen(dip4_err_seen));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic int exp_stat();
    if (m_cont != 0 || m_pos == 0) return 3;
    if (m_pos == N + 1) return (~m_par) & 3;
    return (int'(port_status) >> (2 * m_slot)) & 3;
  endfunction

  task automatic model_clock();
    int e;
    bit hit, cln;
    e = (int'(port_status) >> (2 * m_slot)) & 3;
    if (m_cont != 0) begin
      if (!force_train) begin m_cont = 0; m_pos = 0; m_slot = 0; m_par = 0; end
    end else if (m_pos == N + 1) begin
      m_cont = force_train; m_pos = 0; m_slot = 0; m_par = 0;
    end else begin
      if (m_pos != 0) begin m_par = m_par ^ e; m_slot = (m_slot + 1) % CAL_LEN; end
      m_pos++;
    end
    hit = lock && dip4_vld && (dip4_err != 0);
    cln = lock && dip4_vld && (dip4_err == 0);
    m_seen = hit;
    if (hit) begin
      m_bad++; m_good = 0;
      if (m_bad >= bad_level) m_oos = 1;
    end else if (cln) begin
      m_bad = 0;
      if (m_oos != 0) begin
        m_good++;
        if (m_good >= good_level) begin m_oos = 0; m_good = 0; end
      end else m_good = 0;
    end
  endtask

  task automatic step(int n, bit frc, bit lk, bit vld, logic [LANES-1:0] err);
    for (int i = 0; i < n; i++) begin
      force_train = frc; lock = lk; dip4_vld = vld; dip4_err = err;
      port_status = 8'(cyc * 37 + 11);
      #1;
      chk("R2/R3 stat_out", stat_out, exp_stat());
      chk("R4/R5/R6 force_active", force_active, m_cont);
      chk("R7/R8/R9/R10/R12 oos", oos, m_oos);
      chk("R11 dip4_err_seen", dip4_err_seen, m_seen);
      @(posedge clk);
      model_clock();
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset stat_out", stat_out, 3);
    chk("R1 reset oos", oos, 0);
    chk("R1 reset force_active", force_active, 0);
    chk("R1 reset dip4_err_seen", dip4_err_seen, 0);
    @(negedge clk);
    rst_n = 1;
    step(35, 0, 1, 0, 0);                 // R2, R3 normal frames
    step(3, 1, 1, 0, 0);                  // R5 force mid-frame
    step(20, 1, 1, 1, 4'b0000);           // R4 continuous pattern
    step(1, 0, 1, 0, 0);                  // R6 resume
    step(25, 0, 1, 0, 0);
    step(2, 0, 1, 1, 4'b0001);            // R8 run broken below
    step(1, 0, 1, 1, 4'b0000);
    step(2, 0, 1, 1, 4'b1111);            // R11 multi-lane
    step(3, 0, 0, 1, 4'b0010);            // R10 unlocked ignored
    step(1, 0, 1, 1, 4'b0100);            // R7 reaches threshold
    step(1, 0, 1, 0, 0);
    step(1, 0, 1, 1, 4'b0000);            // R9 partial good run
    step(1, 0, 1, 1, 4'b1000);            // R9 run restarted
    step(3, 0, 0, 1, 4'b0000);            // R10 clean ignored
    step(2, 0, 1, 1, 4'b0000);            // R9 clears
    step(4, 1, 1, 1, 4'b0011);            // R12 errors during force
    step(12, 1, 1, 0, 0);
    step(3, 1, 1, 1, 4'b0000);            // R12 clean during force
    step(12, 0, 1, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule